// File: doc/BRIEF.md
# Paged DMA Address Translator

This block sits between a network controller and its on-board memory. The controller issues 24-bit byte addresses, and the block maps each of them to a physical byte address through a page map that the host writes. Bits 19:10 of the address select one of 1024 map slots. Bits 9:0 pass through unchanged as the offset within a 1 KiB page. The top nibble of the address plays no part in the lookup. Each map slot names one of 256 physical frames, picks on-board or external memory as the target, and chooses the byte order of 16-bit data for that page.

The host reads and writes map slots through a 16-bit register port. The same translation port serves every requester, so host and controller accesses see the same map. A request gives the registered result one cycle later: the physical address, the target select, the swap control, and the outgoing write data, already byte-swapped if the page needs it. Read data returning from memory goes back through the swap that the registered result selected. A slot whose frame field is 256 or more marks the access as a fault and does not issue it.

Top module: `pdma_xlate`

## Requirements
- R1: Address bits 23:20 have no effect on any translation result.
- R2: On an issued access, xo_phys[9:0] equals address bits 9:0 of the request.
- R3: Address bits 19:10 select the map slot, and xo_phys[17:10] carries bits 7:0 of that slot's frame field (slot bits 11:0).
- R4: Slot bit 13 set drives xo_ext high (external memory); slot bit 13 clear drives it low (on-board memory).
- R5: Slot bit 15 clear (controller order) sets xo_swap, and then both xo_wdata and xl_rdata carry their 16-bit input with the two bytes exchanged. Slot bit 15 set passes both unchanged with xo_swap low.
- R6: A frame field of 256 or more gives xo_fault high and xo_valid low, with xo_phys, xo_ext, xo_swap and xo_wdata all zero.
- R7: The results of a request appear on the clock edge after it is taken. A cycle without a request gives xo_valid and xo_fault low at the next edge.
- R8: A host write to a slot shows on cfg_rdata right after the write edge and applies to translations requested in later cycles. A translation requested in the same cycle as the write uses the old slot value.
- R9: After reset every map slot reads as zero and xo_valid, xo_fault and all outputs are zero.
- R10: Slot 1023 translates the top of the space, including address 0xFFFFF4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host write strobe for a map slot |
| cfg_idx | input | 10 | Map slot selected for host read or write |
| cfg_wdata | input | 16 | Slot value to write |
| cfg_rdata | output | 16 | Current value of the selected slot |
| xl_req | input | 1 | Translation request |
| xl_addr | input | 24 | Requested byte address |
| xl_wdata | input | 16 | Write data going to memory |
| mem_rdata | input | 16 | Read data returning from memory |
| xo_valid | output | 1 | Access issued (registered) |
| xo_fault | output | 1 | Frame out of range, access suppressed |
| xo_phys | output | 18 | Physical byte address |
| xo_ext | output | 1 | 1 = external memory, 0 = on-board |
| xo_swap | output | 1 | Byte swap in force for this access |
| xo_wdata | output | 16 | Write data after the order fix |
| xl_rdata | output | 16 | Read data after the order fix |

## Verification
Every translation result is registered, so the bench raises a request at a falling edge and checks the outputs at the next falling edge, one rising edge later. It sets mem_rdata at that same falling edge and reads xl_rdata a moment later, because the read path is combinational after the registered swap flag. A host write is checked on cfg_rdata at the falling edge after its write edge. One case writes a slot and requests a translation through it in the same cycle, and expects the old slot value.

// File: rtl/pdma_xlate.sv
module pdma_xlate #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 10,
  parameter int IDX_W  = 10,
  parameter int FRAMES = 256,
  parameter int ENT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [IDX_W-1:0]              cfg_idx,
  input  logic [ENT_W-1:0]              cfg_wdata,
  output logic [ENT_W-1:0]              cfg_rdata,
  input  logic                          xl_req,
  input  logic [ADDR_W-1:0]             xl_addr,
  input  logic [15:0]                   xl_wdata,
  input  logic [15:0]                   mem_rdata,
  output logic                          xo_valid,
  output logic                          xo_fault,
  output logic [$clog2(FRAMES)+OFF_W-1:0] xo_phys,
  output logic                          xo_ext,
  output logic                          xo_swap,
  output logic [15:0]                   xo_wdata,
  output logic [15:0]                   xl_rdata
);
  localparam int SLOTS   = 1 << IDX_W;
  localparam int FRM_W   = $clog2(FRAMES);
  localparam int PFN_W   = 12;
  localparam int BIT_HOST = 15;
  localparam int BIT_EXT  = 13;

  logic [ENT_W-1:0] map_q [SLOTS];
  logic [ENT_W-1:0] ent;
  logic [IDX_W-1:0] slot;
  logic             bad_frame, swap_n;
  logic             unused_bits;

  assign slot      = xl_addr[OFF_W +: IDX_W];
  assign ent       = map_q[slot];
  assign bad_frame = ent[PFN_W-1:0] >= PFN_W'(FRAMES);
  assign swap_n    = ~ent[BIT_HOST];
  assign cfg_rdata = map_q[cfg_idx];
  assign unused_bits = &{1'b0, xl_addr[ADDR_W-1:OFF_W+IDX_W], ent[14], ent[12]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) map_q[i] <= '0;
    end else if (cfg_we) begin
      map_q[cfg_idx] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xo_valid <= 1'b0;
      xo_fault <= 1'b0;
      xo_phys  <= '0;
      xo_ext   <= 1'b0;
      xo_swap  <= 1'b0;
      xo_wdata <= '0;
    end else if (xl_req) begin
      xo_valid <= ~bad_frame;
      xo_fault <= bad_frame;
      if (bad_frame) begin
        xo_phys  <= '0;
        xo_ext   <= 1'b0;
        xo_swap  <= 1'b0;
        xo_wdata <= '0;
      end else begin
        xo_phys  <= {ent[FRM_W-1:0], xl_addr[OFF_W-1:0]};
        xo_ext   <= ent[BIT_EXT];
        xo_swap  <= swap_n;
        xo_wdata <= swap_n ? {xl_wdata[7:0], xl_wdata[15:8]} : xl_wdata;
      end
    end else begin
      xo_valid <= 1'b0;
      xo_fault <= 1'b0;
    end
  end

  assign xl_rdata = xo_swap ? {mem_rdata[7:0], mem_rdata[15:8]} : mem_rdata;

  p_fault_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xo_fault |-> (!xo_valid && !xo_swap && !xo_ext));
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> (!xo_valid && !xo_fault));
  p_req_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> (xo_valid || xo_fault));
  p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> (xo_fault || xo_phys[OFF_W-1:0] == $past(xl_addr[OFF_W-1:0])));
  p_swap_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && swap_n && !bad_frame) |=> xo_wdata == {$past(xl_wdata[7:0]), $past(xl_wdata[15:8])});
  p_host_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> map_q[$past(cfg_idx)] == $past(cfg_wdata));
endmodule

// File: tb/pdma_xlate_tb_top.sv
module pdma_xlate_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [9:0] cfg_idx = 0;
  logic [15:0] cfg_wdata = 0, cfg_rdata;
  logic xl_req = 0;
  logic [23:0] xl_addr = 0;
  logic [15:0] xl_wdata = 0, mem_rdata = 0, xo_wdata, xl_rdata;
  logic xo_valid, xo_fault, xo_ext, xo_swap;
  logic [17:0] xo_phys;
  logic [15:0] model [1024];
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pdma_xlate dut_i (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .xl_req(xl_req), .xl_addr(xl_addr),
    .xl_wdata(xl_wdata), .mem_rdata(mem_rdata), .xo_valid(xo_valid), .xo_fault(xo_fault),
    .xo_phys(xo_phys), .xo_ext(xo_ext), .xo_swap(xo_swap), .xo_wdata(xo_wdata),
    .xl_rdata(xl_rdata));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] bswap(input logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  function automatic bit e_fault(input logic [15:0] e);
    return e[11:0] >= 12'd256;
  endfunction

  function automatic logic [17:0] e_phys(input logic [15:0] e, input logic [23:0] a);
    return e_fault(e) ? 18'd0 : {e[7:0], a[9:0]};
  endfunction

  task automatic host_write(input logic [9:0] idx, input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_wdata = v;
    model[idx] = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic xlate(input logic [23:0] a, input logic [15:0] wd, input logic [15:0] rd,
                       input logic [15:0] e, input string tag);
    bit f, sw;
    @(negedge clk);
    xl_req = 1; xl_addr = a; xl_wdata = wd;
    @(negedge clk);
    xl_req = 0; mem_rdata = rd;
    #1;
    f  = e_fault(e);
    sw = !f && !e[15];
    chk({tag, " R7/R6 valid"}, xo_valid, !f);
    chk({tag, " R6 fault"}, xo_fault, f);
    chk({tag, " R2/R3 phys"}, xo_phys, e_phys(e, a));
    chk({tag, " R4 ext"}, xo_ext, f ? 1'b0 : e[13]);
    chk({tag, " R5 swap"}, xo_swap, sw);
    chk({tag, " R5 wdata"}, xo_wdata, f ? 16'd0 : (sw ? bswap(wd) : wd));
    chk({tag, " R5 rdata"}, xl_rdata, sw ? bswap(rd) : rd);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] e, old;
    logic [23:0] a;
    logic [17:0] p0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 1024; i++) model[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    cfg_idx = 10'd77; #1;
    chk("R9 slot zero", cfg_rdata, 16'h0);
    chk("R9 valid", xo_valid, 0);
    chk("R9 fault", xo_fault, 0);
    chk("R9 phys", xo_phys, 0);
    chk("R9 wdata", xo_wdata, 0);

    // R8 host readback
    host_write(10'd5, 16'hA0C3);
    cfg_idx = 10'd5; #1;
    chk("R8 readback", cfg_rdata, 16'hA0C3);

    // R4/R5 directed variants of slot 5 (addr bits 19:10 = 5)
    xlate(24'h001655, 16'h1234, 16'hBEEF, model[5], "dir host-order ext");
    host_write(10'd5, 16'h0042);
    xlate(24'h0017FF, 16'hAB01, 16'h55AA, model[5], "dir ctrl-order onboard");
    host_write(10'd5, 16'h20FF);
    xlate(24'h001400, 16'hC0DE, 16'h0F0F, model[5], "dir frame 255");

    // R6 frame out of range: 256 and 0xFFF
    host_write(10'd9, 16'h0100);
    xlate(24'h002412, 16'h7777, 16'h1122, model[9], "R6 frame 256");
    host_write(10'd9, 16'hAFFF);
    xlate(24'h0027FE, 16'h7777, 16'h1122, model[9], "R6 frame fff");

    // R10 last slot, config pointer address
    host_write(10'd1023, 16'hA0FE);
    xlate(24'hFFFFF4, 16'h0102, 16'h0304, model[1023], "R10 top");
    chk("R10 phys exact", xo_phys, {8'hFE, 10'h3F4});

    // R1 top nibble ignored
    host_write(10'd300, 16'h0033);
    a = 24'h04B123;
    xlate({4'h0, a[19:0]}, 16'h1111, 16'h2222, model[300], "R1 nib0");
    p0 = xo_phys;
    xlate({4'hD, a[19:0]}, 16'h1111, 16'h2222, model[300], "R1 nibD");
    chk("R1 same phys", xo_phys, p0);

    // R7 idle cycle after request
    @(negedge clk); #1;
    chk("R7 idle valid", xo_valid, 0);
    chk("R7 idle fault", xo_fault, 0);

    // R8 same-cycle write uses old slot, later request uses new
    old = model[300];
    @(negedge clk);
    cfg_we = 1; cfg_idx = 10'd300; cfg_wdata = 16'h8011;
    xl_req = 1; xl_addr = 24'h04B0AA; xl_wdata = 16'h9876;
    @(negedge clk);
    cfg_we = 0; xl_req = 0; #1;
    chk("R8 same-cycle old phys", xo_phys, e_phys(old, 24'h04B0AA));
    chk("R8 same-cycle old swap", xo_swap, !old[15]);
    model[300] = 16'h8011;
    xlate(24'h04B0AA, 16'h9876, 16'h4321, model[300], "R8 after write");

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned r = $urandom % 10;
      logic [9:0] idx = 10'($urandom);
      if (r < 3) begin
        e = 16'($urandom);
        if ($urandom % 4 != 0) e[11:8] = 4'h0;
        host_write(idx, e);
        cfg_idx = idx; #1;
        chk("R8 rand readback", cfg_rdata, e);
      end else begin
        a = {4'($urandom), idx, 10'($urandom)};
        xlate(a, 16'($urandom), 16'($urandom), model[idx], "rand R3");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule